// File: doc/BRIEF.md
# Gray Pixel Pair Run Compressor

This block shrinks a stream of gray pixel bytes without loss. Each incoming byte carries a 7-bit gray level in its upper bits, so the lowest bit is always free. The compressor uses that spare bit as a "repeat once" marker. When two neighbouring samples match, it sends one byte with the marker set and drops the second sample. A sample with no equal neighbour goes out unchanged, with the marker clear. Pairs never overlap, so a run of three equal samples becomes one marked byte followed by one plain byte. On typical images the stream shrinks by about a quarter to a third.

The same top also holds the inverse path, an expander. For every marked byte it writes two identical samples with the marker cleared. Plain bytes pass through unchanged.

All four streams use a valid/ready handshake with an 8-bit data field and an end-of-frame flag. The compressor holds at most one sample while it waits for that sample's neighbour. At end of frame it flushes that held sample, so a pair never spans two frames.

Top module: `pair_codec`

## Requirements
- R1: While reset is asserted and after it is released, both output valids are low and both input readies are high until traffic arrives.
- R2: Two adjacent compressor inputs within a frame with equal bits 7:1 produce one output byte: those bits, with bit 0 set to 1.
- R3: A compressor input whose next neighbour in the frame differs in bits 7:1 is output alone as those bits with bit 0 equal to 0.
- R4: Pairing does not overlap. After a merged pair, matching restarts at the next sample, so three equal samples give one marked byte and then one plain byte.
- R5: The last output byte of every compressed frame carries the end flag, and only that byte carries it. A held unmatched sample is flushed as a plain byte when its frame ends, and no pair crosses a frame boundary.
- R6: While an output is valid and not accepted, its data and end flag stay unchanged. Backpressure never drops or repeats a byte.
- R7: The expander turns a marked input byte into two consecutive outputs of bits 7:1 with bit 0 equal to 0. Only the second of the two can carry the end flag.
- R8: The expander holds its input ready low in the cycle after it accepts a marked byte, while the second copy is pending.
- R9: Every expander output has bit 0 equal to 0. A plain input byte is output once, unchanged.
- R10: Compressing a frame and then expanding the result reproduces the original samples and frame end under arbitrary valid and ready gaps.
- R11: Bit 0 of a compressor input is ignored. Both the comparison and the output value use only bits 7:1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pk_in_valid | input | 1 | Compressor input valid |
| pk_in_ready | output | 1 | Compressor input ready |
| pk_in_data | input | 8 | Gray sample, level in bits 7:1 |
| pk_in_last | input | 1 | Last sample of frame |
| pk_out_valid | output | 1 | Compressed byte valid |
| pk_out_ready | input | 1 | Compressed byte accepted |
| pk_out_data | output | 8 | Compressed byte, bit 0 is the repeat marker |
| pk_out_last | output | 1 | Last compressed byte of frame |
| up_in_valid | input | 1 | Expander input valid |
| up_in_ready | output | 1 | Expander input ready |
| up_in_data | input | 8 | Compressed byte, bit 0 is the repeat marker |
| up_in_last | input | 1 | Last compressed byte of frame |
| up_out_valid | output | 1 | Expanded sample valid |
| up_out_ready | input | 1 | Expanded sample accepted |
| up_out_data | output | 8 | Expanded gray sample, bit 0 zero |
| up_out_last | output | 1 | Last sample of frame |

## Verification
Each output is registered. A compressed byte appears one cycle after the edge that accepts the sample completing it: either the second sample of a pair or the unequal sample that follows. When a frame ends on a mismatch, the flushed final byte comes one further cycle after the slot frees. The expander shows its first copy one cycle after acceptance, and the second copy on the next edge at which the output slot is free. The bench drives inputs on the falling edge and settles briefly. It then records the handshakes that the coming rising edge will complete. Outputs are compared in order against a model computed from the input arrays, so the checks do not depend on exact latency. The stall-stability and ready-low checks look exactly one cycle after their trigger.

// File: rtl/pair_codec_pkg.sv
package pair_codec_pkg;
   // Position of the repeat marker inside a coded byte.
   localparam int MARK_POS = 0;

   typedef enum logic [0:0] {
      UP_PASS   = 1'b0,
      UP_SECOND = 1'b1
   } up_state_e;
endpackage

// File: rtl/pair_packer.sv
module pair_packer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic [W-1:0] in_data,
   input  logic         in_last,
   output logic         out_valid,
   input  logic         out_ready,
   output logic [W-1:0] out_data,
   output logic         out_last
);
   localparam int GW = W - 1;

   generate
      if (W < 2) begin : g_width_check
         $error("pair_packer: W must leave room for the marker bit");
      end
   endgenerate

   logic          held_vld;
   logic [GW-1:0] held_gray;
   logic          held_end;
   logic          slot_free;
   logic          take;
   logic          flush;
   logic          same;
   logic [GW-1:0] in_gray;

   assign in_gray   = in_data[W-1:1];
   assign slot_free = !out_valid || out_ready;
   assign flush     = held_vld && held_end && slot_free;
   assign in_ready  = slot_free && !(held_vld && held_end);
   assign take      = in_valid && in_ready;
   assign same      = held_vld && (in_gray == held_gray);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_vld  <= 1'b0;
         held_gray <= '0;
         held_end  <= 1'b0;
         out_valid <= 1'b0;
         out_data  <= '0;
         out_last  <= 1'b0;
      end else begin
         if (out_valid && out_ready) out_valid <= 1'b0;
         if (flush) begin
            out_valid <= 1'b1;
            out_data  <= {held_gray, 1'b0};
            out_last  <= 1'b1;
            held_vld  <= 1'b0;
            held_end  <= 1'b0;
         end else if (take) begin
            if (!held_vld) begin
               if (in_last) begin
                  out_valid <= 1'b1;
                  out_data  <= {in_gray, 1'b0};
                  out_last  <= 1'b1;
               end else begin
                  held_vld  <= 1'b1;
                  held_gray <= in_gray;
                  held_end  <= 1'b0;
               end
            end else if (same) begin
               out_valid <= 1'b1;
               out_data  <= {held_gray, 1'b1};
               out_last  <= in_last;
               held_vld  <= 1'b0;
            end else begin
               out_valid <= 1'b1;
               out_data  <= {held_gray, 1'b0};
               out_last  <= 1'b0;
               held_gray <= in_gray;
               held_end  <= in_last;
            end
         end
      end
   end
endmodule

// File: rtl/pair_unpacker.sv
module pair_unpacker
   import pair_codec_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic [W-1:0] in_data,
   input  logic         in_last,
   output logic         out_valid,
   input  logic         out_ready,
   output logic [W-1:0] out_data,
   output logic         out_last
);
   localparam int GW = W - 1;

   generate
      if (W < 2) begin : g_width_check
         $error("pair_unpacker: W must leave room for the marker bit");
      end
   endgenerate

   up_state_e     state;
   logic [GW-1:0] rep_gray;
   logic          rep_end;
   logic          slot_free;
   logic          take;
   logic          marked;

   assign slot_free = !out_valid || out_ready;
   assign in_ready  = slot_free && (state == UP_PASS);
   assign take      = in_valid && in_ready;
   assign marked    = in_data[MARK_POS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= UP_PASS;
         rep_gray  <= '0;
         rep_end   <= 1'b0;
         out_valid <= 1'b0;
         out_data  <= '0;
         out_last  <= 1'b0;
      end else begin
         if (out_valid && out_ready) out_valid <= 1'b0;
         if (state == UP_SECOND && slot_free) begin
            out_valid <= 1'b1;
            out_data  <= {rep_gray, 1'b0};
            out_last  <= rep_end;
            state     <= UP_PASS;
         end else if (take) begin
            out_valid <= 1'b1;
            out_data  <= {in_data[W-1:1], 1'b0};
            out_last  <= in_last && !marked;
            if (marked) begin
               state    <= UP_SECOND;
               rep_gray <= in_data[W-1:1];
               rep_end  <= in_last;
            end
         end
      end
   end
endmodule

// File: rtl/pair_codec.sv
module pair_codec #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         pk_in_valid,
   output logic         pk_in_ready,
   input  logic [W-1:0] pk_in_data,
   input  logic         pk_in_last,
   output logic         pk_out_valid,
   input  logic         pk_out_ready,
   output logic [W-1:0] pk_out_data,
   output logic         pk_out_last,
   input  logic         up_in_valid,
   output logic         up_in_ready,
   input  logic [W-1:0] up_in_data,
   input  logic         up_in_last,
   output logic         up_out_valid,
   input  logic         up_out_ready,
   output logic [W-1:0] up_out_data,
   output logic         up_out_last
);
   pair_packer #(.W(W)) u_pack (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (pk_in_valid),
      .in_ready  (pk_in_ready),
      .in_data   (pk_in_data),
      .in_last   (pk_in_last),
      .out_valid (pk_out_valid),
      .out_ready (pk_out_ready),
      .out_data  (pk_out_data),
      .out_last  (pk_out_last)
   );

   pair_unpacker #(.W(W)) u_unpack (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (up_in_valid),
      .in_ready  (up_in_ready),
      .in_data   (up_in_data),
      .in_last   (up_in_last),
      .out_valid (up_out_valid),
      .out_ready (up_out_ready),
      .out_data  (up_out_data),
      .out_last  (up_out_last)
   );
endmodule

// File: rtl/pair_codec_chk.sv
module pair_codec_chk #(
   parameter int W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         pk_in_valid,
   input logic         pk_in_ready,
   input logic [W-1:0] pk_in_data,
   input logic         pk_in_last,
   input logic         pk_out_valid,
   input logic         pk_out_ready,
   input logic [W-1:0] pk_out_data,
   input logic         pk_out_last,
   input logic         up_in_valid,
   input logic         up_in_ready,
   input logic [W-1:0] up_in_data,
   input logic         up_in_last,
   input logic         up_out_valid,
   input logic         up_out_ready,
   input logic [W-1:0] up_out_data,
   input logic         up_out_last
);
   assert_pk_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pk_out_valid && !pk_out_ready |=>
         pk_out_valid && $stable(pk_out_data) && $stable(pk_out_last));

   assert_up_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      up_out_valid && !up_out_ready |=>
         up_out_valid && $stable(up_out_data) && $stable(up_out_last));

   assert_up_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      up_in_valid && up_in_ready && up_in_data[0] |=> !up_in_ready);

   assert_up_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
      up_in_valid && up_in_ready && up_in_data[0] |=>
         up_out_valid && !up_out_last && (up_out_data[W-1:1] == $past(up_in_data[W-1:1])));

   assert_up_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      up_out_valid |-> !up_out_data[0]);
endmodule

bind pair_codec pair_codec_chk #(.W(W)) u_chk (.*);

// File: tb/pair_codec_bench.sv
module pair_codec_bench;
   localparam int CLK_PERIOD = 10;
   localparam int W = 8;
   localparam int MAXN = 512;
   localparam int FRAME_LIMIT = 6000;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         pk_in_valid = 1'b0, pk_in_last = 1'b0, pk_out_ready = 1'b0;
   logic [W-1:0] pk_in_data = '0;
   logic         up_in_valid = 1'b0, up_in_last = 1'b0, up_out_ready = 1'b0;
   logic [W-1:0] up_in_data = '0;
   logic         pk_in_ready, pk_out_valid, pk_out_last;
   logic [W-1:0] pk_out_data;
   logic         up_in_ready, up_out_valid, up_out_last;
   logic [W-1:0] up_out_data;

   logic [W-1:0] src [0:MAXN-1];
   logic [W-1:0] exc [0:MAXN-1];
   logic         exl [0:MAXN-1];
   int nsrc, nexc;
   int checks = 0, fails = 0;
   logic [15:0] lfsr = 16'hACE1;

   always #(CLK_PERIOD/2) clk = ~clk;

   pair_codec #(.W(W)) u_pair_codec (.*);

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Compressed stream model: pairs on bits 7:1, non-overlapping, end flag on final byte.
   task automatic build_expect();
      int i = 0;
      nexc = 0;
      while (i < nsrc) begin
         if (i + 1 < nsrc && src[i][W-1:1] == src[i+1][W-1:1]) begin
            exc[nexc] = {src[i][W-1:1], 1'b1};
            exl[nexc] = (i + 1 == nsrc - 1);
            i += 2;
         end else begin
            exc[nexc] = {src[i][W-1:1], 1'b0};
            exl[nexc] = (i == nsrc - 1);
            i += 1;
         end
         nexc++;
      end
   endtask

   task automatic run_frame(input string req, input bit bp);
      int ci = 0, co = 0, di = 0, uo = 0, cyc = 0;
      bit pk_stall = 0, up_stall = 0, up_mark = 0;
      logic [W-1:0] pk_hd = '0, up_hd = '0;
      logic pk_hl = 0, up_hl = 0;
      build_expect();
      while (!(co == nexc && uo == nsrc)) begin
         @(negedge clk);
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         if (pk_stall)
            check(pk_out_valid && pk_out_data == pk_hd && pk_out_last == pk_hl,
                  "R6", "compressed byte moved under stall", int'(pk_out_data), int'(pk_hd));
         if (up_stall)
            check(up_out_valid && up_out_data == up_hd && up_out_last == up_hl,
                  "R6", "expanded byte moved under stall", int'(up_out_data), int'(up_hd));
         if (up_mark)
            check(!up_in_ready, "R8", "ready after marked byte", int'(up_in_ready), 0);
         pk_in_valid  = (ci < nsrc) && (!bp || lfsr[0]);
         pk_in_data   = (ci < nsrc) ? src[ci] : '0;
         pk_in_last   = (ci == nsrc - 1);
         pk_out_ready = !bp || lfsr[3];
         up_in_valid  = (di < nexc) && (!bp || lfsr[6]);
         up_in_data   = (di < nexc) ? exc[di] : '0;
         up_in_last   = (di < nexc) ? exl[di] : 1'b0;
         up_out_ready = !bp || lfsr[9];
         #1;
         if (pk_in_valid && pk_in_ready) ci++;
         up_mark = 0;
         if (up_in_valid && up_in_ready) begin
            up_mark = up_in_data[0];
            di++;
         end
         if (pk_out_valid && pk_out_ready) begin
            if (co < nexc) begin
               check(pk_out_data == exc[co], req, "compressed data", int'(pk_out_data), int'(exc[co]));
               check(pk_out_last == exl[co], "R5", "compressed end flag", int'(pk_out_last), int'(exl[co]));
            end else
               check(0, req, "extra compressed byte", int'(pk_out_data), 0);
            co++;
         end
         if (up_out_valid && up_out_ready) begin
            if (uo < nsrc) begin
               check(up_out_data == {src[uo][W-1:1], 1'b0}, "R10", "expanded data",
                     int'(up_out_data), int'({src[uo][W-1:1], 1'b0}));
               check(up_out_last == (uo == nsrc - 1), "R7", "expanded end flag",
                     int'(up_out_last), int'(uo == nsrc - 1));
               check(!up_out_data[0], "R9", "expanded bit 0", int'(up_out_data[0]), 0);
            end else
               check(0, "R10", "extra expanded byte", int'(up_out_data), 0);
            uo++;
         end
         pk_stall = pk_out_valid && !pk_out_ready;
         pk_hd = pk_out_data; pk_hl = pk_out_last;
         up_stall = up_out_valid && !up_out_ready;
         up_hd = up_out_data; up_hl = up_out_last;
         cyc++;
         if (cyc > FRAME_LIMIT) begin
            check(0, req, "watchdog expired", co, nexc);
            break;
         end
      end
      @(negedge clk);
      pk_in_valid = 0; up_in_valid = 0; pk_out_ready = 1; up_out_ready = 1;
      repeat (3) @(negedge clk);
      check(!pk_out_valid && !up_out_valid, req, "idle after frame",
            int'({pk_out_valid, up_out_valid}), 0);
      check(ci == nsrc && di == nexc, req, "inputs consumed", ci, nsrc);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(!pk_out_valid && !up_out_valid, "R1", "valids in reset",
            int'({pk_out_valid, up_out_valid}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!pk_out_valid && !up_out_valid && pk_in_ready && up_in_ready, "R1",
            "state after reset",
            int'({pk_out_valid, up_out_valid, pk_in_ready, up_in_ready}), 3);

      // R3: every gray level, adjacent all distinct
      nsrc = 128;
      for (int i = 0; i < 128; i++) src[i] = W'(i << 1);
      run_frame("R3", 0);

      // R2: every gray level as an equal pair
      nsrc = 256;
      for (int i = 0; i < 256; i++) src[i] = W'((i / 2) << 1);
      run_frame("R2", 0);

      // R4: runs of three
      nsrc = 120;
      for (int i = 0; i < 120; i++) src[i] = W'(((i / 3) * 3 % 128) << 1);
      run_frame("R4", 0);

      // R5: short frames and tail cases
      nsrc = 1; src[0] = 8'h42; run_frame("R5", 0);
      nsrc = 2; src[0] = 8'h10; src[1] = 8'h10; run_frame("R5", 0);
      nsrc = 2; src[0] = 8'h10; src[1] = 8'h12; run_frame("R5", 0);
      nsrc = 3; src[0] = 8'h20; src[1] = 8'h20; src[2] = 8'h22; run_frame("R5", 0);
      nsrc = 3; src[0] = 8'h20; src[1] = 8'h24; src[2] = 8'h24; run_frame("R5", 0);
      nsrc = 3; src[0] = 8'hFE; src[1] = 8'hFE; src[2] = 8'hFE; run_frame("R5", 1);

      // R11: noise on bit 0
      nsrc = 200;
      for (int i = 0; i < 200; i++)
         src[i] = W'((((i >> 1) % 5) << 1) | ((i % 3) == 0 ? 1 : 0));
      run_frame("R11", 0);

      // R2 and R3 sweep: each level next to itself and to its neighbour level
      nsrc = 384;
      for (int i = 0; i < 128; i++) begin
         src[3*i]   = W'(i << 1);
         src[3*i+1] = W'(i << 1);
         src[3*i+2] = W'(((i + 1) % 128) << 1);
      end
      run_frame("R2", 1);

      // R6 and R10: mixed runs under random gaps
      nsrc = 400;
      for (int i = 0; i < 400; i++) src[i] = W'(((i * i + i / 3) % 3) << 1);
      run_frame("R6", 1);
      nsrc = 256;
      for (int i = 0; i < 256; i++) src[i] = W'((((i / 2) * 37) % 128) << 1);
      run_frame("R10", 1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule